// File: doc/BRIEF.md
# Multiplexed Display Scanner with Refresh Watchdog

This block runs a time-shared front-panel display. A 4-bit scan code steps through sixteen slots in binary order and wraps. A clock-enable divider sets the length of each slot. The scan code is decoded into active-low strobes. Codes 0 through 8 each enable one of nine digit/indicator drivers. While a driver is enabled, the segment pattern supplied for that slot appears on the segment lines. Codes 9 through 15 enable no driver. Code 9 also serves as the frame mark. A second decoder uses only the three low scan bits and drives six row strobes, so each row strobe is active in two slots per frame.

A retriggerable watchdog guards the refresh. It reloads each time the scan code enters the frame-mark value. Its timeout is set slightly longer than one full frame. If the scan stalls, the timeout expires, and the watchdog forces every driver strobe off and clears the segment lines. The `scan_run` input gates the scan, and its low level is how the scan stalls. After reset the display is blanked until the first frame mark arrives.

Top module: `disp_scan_top`

## Requirements
- R1: While `scan_run` is high, `scan_sel` advances by one every `SLOT_DIV` clock cycles. It counts in binary from 0 to 15 and then wraps to 0.
- R2: While `scan_run` is low, `scan_sel` holds its value.
- R3: `drv_sel_n[k]` (k = 0..8) is low exactly when `scan_sel` equals k and `blank` is low. At most one driver strobe is low at any time.
- R4: When `scan_sel` holds a code from 9 to 15, all driver strobes are high and `seg_out` is 0.
- R5: In slot k, with `blank` low, `seg_out` equals `slot_seg[k*SEG_W +: SEG_W]`.
- R6: `row_sel_n[j]` (j = 0..5) is low exactly when `scan_sel[2:0]` equals j. This does not depend on `blank`. Low-bit codes 6 and 7 select no row.
- R7: During reset and in the first cycle after it, `scan_sel` is 0, `blank` is 1, all driver strobes are high, `seg_out` is 0 and `row_sel_n` is 6'b111110.
- R8: When `scan_sel` enters code 9 from another code, `blank` goes low one clock later.
- R9: While the scan runs without interruption, `blank` stays low in every frame after the first frame mark.
- R10: After the last entry into code 9, `blank` rises exactly `WDOG_TICKS+1` clocks later if no new entry occurs. A scan that stalls on code 9 itself does not reload the watchdog. While `blank` is high, all driver strobes are high and `seg_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_run | input | 1 | Scan enable; low stalls the scan code |
| slot_seg | input | NUM_DRV*SEG_W | Segment pattern for each of the nine driven slots, slot k at bits k*SEG_W upward |
| scan_sel | output | 4 | Current scan code |
| drv_sel_n | output | NUM_DRV | Active-low driver strobes, one per slot 0..8 |
| row_sel_n | output | NUM_ROW | Active-low row strobes decoded from the low three scan bits |
| seg_out | output | SEG_W | Segment lines for the driver that is currently enabled |
| blank | output | 1 | High while the watchdog holds the display dark |

## Verification
The scan is first run across whole frames with two segment data sets: a distinct value per slot, then the bitwise complement of that set. These runs separate a wrong slot-to-data mapping from a stuck or swapped segment bit, and they show whether the idle slots 9 to 15 leak data. A stall in the middle of a frame shows whether the timeout blanks the drivers while the row strobes keep following the held code. A stall on the frame-mark slot itself is timed to the exact cycle. It separates a watchdog that triggers on the edge of the mark from one that triggers on its level, and it catches an off-by-one error in the timeout. Resuming after each stall confirms that the display releases on the next entry to the frame mark.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    localparam int SCAN_W      = 4;
    localparam int SCAN_STATES = 1 << SCAN_W;
    typedef logic [SCAN_W-1:0] scan_t;
endpackage

// File: rtl/dsc_slot_div.sv
module dsc_slot_div #(
    parameter int SLOT_DIV = 31250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int DIV_W = (SLOT_DIV > 1) ? $clog2(SLOT_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(SLOT_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (run) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                tick     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (SLOT_DIV > 1) begin : g_spacing
            // R1: slot enables never come back to back when a slot spans several clocks
            a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/dsc_scan_ctr.sv
module dsc_scan_ctr import dsc_pkg::*; (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    output scan_t scan
);
    typedef struct packed {
        scan_t code;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) st_d.code = st_q.code + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scan = st_q.code;

    // R1: the code only ever moves forward by one, wrapping 15 -> 0
    a_r1_scan_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.code) |-> (st_q.code == scan_t'($past(st_q.code) + 1'b1)));
endmodule

// File: rtl/dsc_wdog.sv
module dsc_wdog #(
    parameter int WDOG_TICKS = 550000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark,
    output logic blank
);
    localparam int TMR_W = $clog2(WDOG_TICKS + 1);
    localparam logic [TMR_W-1:0] RELOAD = TMR_W'(WDOG_TICKS);

    typedef struct packed {
        logic             mark_seen;
        logic [TMR_W-1:0] tmr;
    } wd_st_t;

    wd_st_t st_d, st_q;
    logic   kick;

    always_comb begin
        st_d           = st_q;
        kick           = mark && !st_q.mark_seen;
        st_d.mark_seen = mark;
        if (kick) begin
            st_d.tmr = RELOAD;
        end else if (st_q.tmr != '0) begin
            st_d.tmr = st_q.tmr - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign blank = (st_q.tmr == '0);

    // R8: a fresh frame mark releases the display on the next clock
    a_r8_kick_releases: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !blank);
    // R10: once dark, only a new frame mark can light the display again
    a_r10_dark_until_kick: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !kick) |=> blank);
endmodule

// File: rtl/dsc_decode.sv
module dsc_decode import dsc_pkg::*; #(
    parameter int NUM_DRV = 9,
    parameter int NUM_ROW = 6,
    parameter int SEG_W   = 8
) (
    input  scan_t                      scan,
    input  logic                       blank,
    input  logic [NUM_DRV*SEG_W-1:0]   slot_seg,
    output logic [NUM_DRV-1:0]         drv_sel_n,
    output logic [NUM_ROW-1:0]         row_sel_n,
    output logic [SEG_W-1:0]           seg_out,
    output logic                       mark
);
    localparam int    ROW_W     = (NUM_ROW > 1) ? $clog2(NUM_ROW) : 1;
    localparam scan_t MARK_CODE = scan_t'(NUM_DRV);

    logic [NUM_DRV-1:0]            drv_hit;
    logic [NUM_DRV-1:0][SEG_W-1:0] seg_mask;

    generate
        for (genvar k = 0; k < NUM_DRV; k++) begin : g_drv
            assign drv_hit[k]   = (scan == scan_t'(k)) && !blank;
            assign drv_sel_n[k] = ~drv_hit[k];
            assign seg_mask[k]  = drv_hit[k] ? slot_seg[k*SEG_W +: SEG_W] : '0;
        end
        for (genvar j = 0; j < NUM_ROW; j++) begin : g_row
            assign row_sel_n[j] = ~(scan[ROW_W-1:0] == ROW_W'(j));
        end
    endgenerate

    always_comb begin
        seg_out = '0;
        for (int k = 0; k < NUM_DRV; k++) begin
            seg_out = seg_out | seg_mask[k];
        end
    end

    assign mark = (scan == MARK_CODE);
endmodule

// File: rtl/disp_scan_top.sv
module disp_scan_top import dsc_pkg::*; #(
    parameter int SLOT_DIV   = 31250,
    parameter int WDOG_TICKS = 550000,
    parameter int NUM_DRV    = 9,
    parameter int NUM_ROW    = 6,
    parameter int SEG_W      = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scan_run,
    input  logic [NUM_DRV*SEG_W-1:0] slot_seg,
    output logic [SCAN_W-1:0]        scan_sel,
    output logic [NUM_DRV-1:0]       drv_sel_n,
    output logic [NUM_ROW-1:0]       row_sel_n,
    output logic [SEG_W-1:0]         seg_out,
    output logic                     blank
);
    logic  slot_tick;
    logic  frame_mark;
    scan_t scan_code;

    dsc_slot_div #(.SLOT_DIV(SLOT_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (scan_run),
        .tick  (slot_tick)
    );

    dsc_scan_ctr u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (slot_tick),
        .scan  (scan_code)
    );

    dsc_decode #(.NUM_DRV(NUM_DRV), .NUM_ROW(NUM_ROW), .SEG_W(SEG_W)) u_dec (
        .scan      (scan_code),
        .blank     (blank),
        .slot_seg  (slot_seg),
        .drv_sel_n (drv_sel_n),
        .row_sel_n (row_sel_n),
        .seg_out   (seg_out),
        .mark      (frame_mark)
    );

    dsc_wdog #(.WDOG_TICKS(WDOG_TICKS)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .mark  (frame_mark),
        .blank (blank)
    );

    assign scan_sel = scan_code;

    // R2: a stalled scan keeps its code
    a_r2_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(scan_run) |-> $stable(scan_sel));
    // R3: never two drivers at once
    a_r3_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~drv_sel_n));
    // R4: idle slots leave every driver off
    a_r4_idle_slots_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_sel >= SCAN_W'(NUM_DRV)) |-> (&drv_sel_n && seg_out == '0));
    // R6: at most one row strobe active
    a_r6_one_row: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~row_sel_n));
    // R10: a blanked display drives nothing
    a_r10_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (&drv_sel_n && seg_out == '0));
endmodule

// File: tb/disp_scan_top_bench.sv
module disp_scan_top_bench;
    localparam int D     = 4;
    localparam int T     = 70;
    localparam int ND    = 9;
    localparam int NR    = 6;
    localparam int SW    = 8;
    localparam int FRAME = 16 * D;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             scan_run;
    logic [ND*SW-1:0] slot_seg;
    logic [3:0]       scan_sel;
    logic [ND-1:0]    drv_sel_n;
    logic [NR-1:0]    row_sel_n;
    logic [SW-1:0]    seg_out;
    logic             blank;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    disp_scan_top #(.SLOT_DIV(D), .WDOG_TICKS(T), .NUM_DRV(ND), .NUM_ROW(NR), .SEG_W(SW)) u_disp_scan_top (
        .clk(clk), .rst_n(rst_n), .scan_run(scan_run), .slot_seg(slot_seg),
        .scan_sel(scan_sel), .drv_sel_n(drv_sel_n), .row_sel_n(row_sel_n),
        .seg_out(seg_out), .blank(blank)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [ND-1:0] exp_drv(input logic [3:0] s, input logic b);
        logic [ND-1:0] r = '1;
        if (!b && s < ND) r[s] = 1'b0;
        return r;
    endfunction

    function automatic logic [NR-1:0] exp_row(input logic [3:0] s);
        logic [NR-1:0] r = '1;
        if (s[2:0] < NR) r[s[2:0]] = 1'b0;
        return r;
    endfunction

    function automatic logic [SW-1:0] exp_seg(input logic [3:0] s, input logic b);
        if (b || s >= ND) return '0;
        return slot_seg[s*SW +: SW];
    endfunction

    task automatic chk_ports(input string tag);
        chk({"R3 drv ", tag}, 32'(drv_sel_n), 32'(exp_drv(scan_sel, blank)));
        chk({"R6 row ", tag}, 32'(row_sel_n), 32'(exp_row(scan_sel)));
        chk({"R5/R4 seg ", tag}, 32'(seg_out), 32'(exp_seg(scan_sel, blank)));
    endtask

    task automatic set_pattern(input bit invert);
        for (int k = 0; k < ND; k++) begin
            slot_seg[k*SW +: SW] = invert ? ~(8'h11 * 8'(k + 1)) : 8'h11 * 8'(k + 1);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; scan_run = 1'b1; set_pattern(1'b0);
        repeat (3) @(negedge clk);
        chk("R7 scan in reset", 32'(scan_sel), 0);
        chk("R7 blank in reset", 32'(blank), 1);
        chk("R7 drv in reset", 32'(drv_sel_n), 32'(9'h1FF));
        chk("R7 seg in reset", 32'(seg_out), 0);
        chk("R7 row in reset", 32'(row_sel_n), 32'(6'b111110));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 scan after reset", 32'(scan_sel), 0);
        chk("R7 blank after reset", 32'(blank), 1);
        chk("R7 drv after reset", 32'(drv_sel_n), 32'(9'h1FF));
    endtask

    task automatic t_first_release();
        int edges = 1;
        while (scan_sel != 4'd9 && edges < 200) begin
            chk("R8 blank before first mark", 32'(blank), 1);
            @(negedge clk); edges++;
        end
        chk("R1 clocks to reach slot 9", 32'(edges), 32'(9 * D));
        chk("R8 blank on mark cycle", 32'(blank), 1);
        @(negedge clk);
        chk("R8 blank one clock after mark", 32'(blank), 0);
        chk("R4 drv in slot 9", 32'(drv_sel_n), 32'(9'h1FF));
    endtask

    task automatic t_walk(input int frames);
        logic [3:0] prev = scan_sel;
        int run_len = 0;
        bit synced = 1'b0;
        for (int c = 0; c < frames * FRAME; c++) begin
            @(negedge clk);
            run_len++;
            if (scan_sel != prev) begin
                chk("R1 step by one", 32'(scan_sel), 32'(4'(prev + 1)));
                if (synced) chk("R1 slot length", 32'(run_len), 32'(D));
                synced = 1'b1; run_len = 0; prev = scan_sel;
            end
            chk("R9 blank while running", 32'(blank), 0);
            chk_ports("walk");
        end
    endtask

    task automatic t_stall_mid();
        logic [3:0] held;
        while (scan_sel != 4'd3) @(negedge clk);
        scan_run = 1'b0;
        held = scan_sel;
        for (int c = 0; c < T + FRAME; c++) begin
            @(negedge clk);
            chk("R2 scan held", 32'(scan_sel), 32'(held));
            chk_ports("stall");
        end
        chk("R10 blank after stall", 32'(blank), 1);
        chk("R10 drv dark", 32'(drv_sel_n), 32'(9'h1FF));
        chk("R10 seg dark", 32'(seg_out), 0);
        chk("R6 row while blanked", 32'(row_sel_n), 32'(6'b110111));
    endtask

    task automatic t_resume();
        int guard = 0;
        logic [3:0] prev;
        scan_run = 1'b1;
        prev = scan_sel;
        @(negedge clk);
        while (!(scan_sel == 4'd9 && prev != 4'd9) && guard < 3 * FRAME) begin
            prev = scan_sel; @(negedge clk); guard++;
        end
        chk("R8 mark reached on resume", 32'(scan_sel), 9);
        @(negedge clk);
        chk("R8 release on resume", 32'(blank), 0);
    endtask

    task automatic t_stall_on_mark();
        while (!(scan_sel == 4'd9 && blank == 1'b0)) @(negedge clk);
        scan_run = 1'b0;
        repeat (T - 1) @(negedge clk);
        chk("R10 still lit one clock before timeout", 32'(blank), 0);
        chk("R2 held on mark", 32'(scan_sel), 9);
        @(negedge clk);
        chk("R10 timeout while parked on mark", 32'(blank), 1);
        repeat (5) @(negedge clk);
        chk("R10 no reload from held mark", 32'(blank), 1);
        chk_ports("parked");
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_first_release();
        t_walk(2);
        set_pattern(1'b1);
        t_walk(2);
        t_stall_mid();
        t_resume();
        set_pattern(1'b0);
        t_walk(1);
        t_stall_on_mark();
        t_resume();
        t_walk(1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule